// File: doc/BRIEF.md
# Non-Retriggerable Clocked Pulse Stretcher

This block is a clocked one-shot. A single-bit trigger is sampled once per clock. The trigger may come from a source that is not aligned to the clock, so it first passes through a two-flop alignment chain. When the aligned trigger shows a 1 while the block is idle, the output goes high for exactly `PULSE_LEN` consecutive clock cycles. Any trigger activity during that window is ignored, so a trigger arriving inside the window neither lengthens nor restarts it.

The window is timed with a binary down-counter of `$clog2(PULSE_LEN+1)` bits rather than with one flop per cycle, so a pulse of several thousand cycles still costs only a handful of registers. The design is split into a control module and a counter datapath under a thin top. The control sends load and decrement strobes to the counter, and the counter reports back when it reaches zero. On the last cycle of a pulse the block checks the trigger once more. If the trigger is 1 at that point, the next pulse begins with no idle cycle in between.

Top module: `oneshot_stretch`

## Requirements
- R1: While `rst` is high, and on the cycle after any clock edge at which `rst` was sampled high, `pulseOut` is 0. Reset also clears the trigger alignment chain, so a trigger sampled before or during reset never produces a pulse.
- R2: If `trigIn` is sampled 1 at clock edge k and the block is idle at edge k+2, then `pulseOut` rises right after edge k+2. That is a latency of three edges, counting the capture edge.
- R3: Each accepted trigger gives exactly `PULSE_LEN` consecutive high cycles on `pulseOut`.
- R4: `trigIn` values that reach the control on any cycle of a pulse except its last have no effect. The pulse still falls exactly `PULSE_LEN` cycles after it rose.
- R5: If `trigIn` stays high for a long time, pulses follow one another with zero idle cycles. An input held high for 30 edges with `PULSE_LEN` = 12 keeps `pulseOut` high for 36 cycles.
- R6: A trigger sampled at edge k+`PULSE_LEN` restarts the window at once, where edge k is the capture edge of the trigger that started the pulse. This gives 2·`PULSE_LEN` contiguous high cycles. A trigger sampled at edge k+`PULSE_LEN`−1 is ignored.
- R7: With `PULSE_LEN` = 1, each accepted trigger gives a single-cycle pulse. A trigger held high for m edges gives m contiguous high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigIn | input | 1 | Trigger, possibly not aligned to `clk` |
| pulseOut | output | 1 | Stretched pulse, high for `PULSE_LEN` cycles |

## Verification
The bench targets the last cycle of the window from both sides. A trigger that reaches the control exactly on the final active cycle must chain a second pulse. A trigger that arrives one cycle earlier must vanish. A design that re-armed one cycle too early would stretch the pulse on the early trigger. A design that re-armed one cycle too late would insert a gap or drop the late trigger. Narrow triggers scattered inside the window catch a retriggerable design, which would produce a pulse longer than `PULSE_LEN`. A long held trigger catches an off-by-one in the reload value, which would shift the 3·`PULSE_LEN` total. A second instance with `PULSE_LEN` = 1 exercises the corner where the load value and zero coincide, so there the counter never counts.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } osState_t;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= asyncIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/oneshot_count.sv
module oneshot_count
  import oneshot_pkg::*;
#(
  parameter int PULSE_LEN = 1000,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  cntStrobe_t strobe,
  output logic       cntZero
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (strobe.load) cnt <= LOAD_VAL;
    else if (strobe.dec)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // R3: count never leaves the range 0..PULSE_LEN-1
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_VAL);

  // R3: a load always lands on PULSE_LEN-1
  a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> cnt == LOAD_VAL);

  // R4: decrement moves down by exactly one
  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (strobe.dec && !strobe.load) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trigSync,
  input  logic       cntZero,
  output cntStrobe_t strobe,
  output logic       active
);
  osState_t state, stateNext;
  logic lastCycle;

  assign lastCycle = (state == ST_ACTIVE) && cntZero;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (trigSync) begin
          strobe.load = 1'b1;
          stateNext   = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (!cntZero) begin
          strobe.dec = 1'b1;
        end else if (trigSync) begin
          strobe.load = 1'b1;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign active = (state == ST_ACTIVE);

  // R2: idle plus aligned trigger starts a pulse on the next cycle
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (!active && trigSync) |=> active);

  // R4: mid-window the trigger is ignored and the pulse holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !cntZero) |=> active);

  // R5: last cycle with trigger re-arms with no gap
  a_r5_rearm: assert property (@(posedge clk) disable iff (rst)
    (lastCycle && trigSync) |=> active);

  // R3: last cycle without trigger ends the pulse
  a_r3_end: assert property (@(posedge clk) disable iff (rst)
    (lastCycle && !trigSync) |=> !active);

  // R1: reset leaves the block idle
  a_r1_reset: assert property (@(posedge clk)
    rst |=> !active);
endmodule

// File: rtl/oneshot_stretch.sv
module oneshot_stretch
  import oneshot_pkg::*;
#(
  parameter int PULSE_LEN   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trigIn,
  output logic pulseOut
);
  logic       trigSync;
  logic       cntZero;
  cntStrobe_t strobe;
  logic       active;

  initial begin
    a_param_len: assert (PULSE_LEN >= 1);
    a_param_sync: assert (SYNC_STAGES >= 2);
  end

  oneshot_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst(rst), .asyncIn(trigIn), .syncOut(trigSync)
  );

  oneshot_ctrl uCtrl (
    .clk(clk), .rst(rst), .trigSync(trigSync), .cntZero(cntZero),
    .strobe(strobe), .active(active)
  );

  oneshot_count #(.PULSE_LEN(PULSE_LEN)) uCount (
    .clk(clk), .rst(rst), .strobe(strobe), .cntZero(cntZero)
  );

  assign pulseOut = active;
endmodule

// File: tb/sim_oneshot_stretch.sv
`timescale 1ns/1ps
module sim_oneshot_stretch;
  localparam int N0 = 12;
  localparam int N1 = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigIn = 1'b0;
  logic out0, out1;

  int checks = 0;
  int errors = 0;
  int rem0 = 0, rem1 = 0;
  logic h1 = 1'b0, h2 = 1'b0;
  int hi0 = 0, hi1 = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oneshot_stretch #(.PULSE_LEN(N0)) u0 (
    .clk(clk), .rst(rst), .trigIn(trigIn), .pulseOut(out0)
  );
  oneshot_stretch #(.PULSE_LEN(N1)) u1 (
    .clk(clk), .rst(rst), .trigIn(trigIn), .pulseOut(out1)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference: value sampled two edges earlier reaches the control now
  function automatic int nextRem(int rem, logic d, int n);
    if (rem > 1) return rem - 1;
    return d ? n : 0;
  endfunction

  // Called at a negedge: drive, take one edge, compare at next negedge
  task automatic tick(input logic v, input logic r, input string tag);
    logic d;
    trigIn = v;
    rst = r;
    @(posedge clk);
    if (r) begin
      rem0 = 0; rem1 = 0; h1 = 1'b0; h2 = 1'b0;
    end else begin
      d = h2;
      h2 = h1;
      h1 = v;
      rem0 = nextRem(rem0, d, N0);
      rem1 = nextRem(rem1, d, N1);
    end
    @(negedge clk);
    check({tag, " u0"}, int'(out0), int'(rem0 > 0));
    check({tag, " u1"}, int'(out1), int'(rem1 > 0));
    if (out0) hi0++;
    if (out1) hi1++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, tag);
  endtask

  task automatic t_reset;
    hi0 = 0;
    tick(1'b1, 1'b1, "R1 reset");
    tick(1'b1, 1'b1, "R1 reset");
    tick(1'b0, 1'b1, "R1 reset");
    idle(N0 + 4, "R1 after reset");
    check("R1 no pulse from trigger held in reset", hi0, 0);
  endtask

  task automatic t_single;
    int riseAt;
    hi0 = 0; hi1 = 0; riseAt = -1;
    tick(1'b1, 1'b0, "R2 single");
    for (int i = 1; i <= N0 + 6; i++) begin
      tick(1'b0, 1'b0, "R2 single");
      if (out0 && riseAt < 0) riseAt = i;
    end
    check("R2 rise after third edge", riseAt, 2);
    check("R3 width N", hi0, N0);
    check("R7 width one", hi1, 1);
  endtask

  task automatic t_narrow;
    hi0 = 0;
    tick(1'b1, 1'b0, "R4 narrow");
    for (int i = 1; i <= N0 + 6; i++)
      tick((i == 3 || i == 6 || i == 9 || i == N0 - 1) ? 1'b1 : 1'b0,
           1'b0, "R4 narrow");
    check("R4 window not extended", hi0, N0);
    idle(N0 + 4, "R4 drain");
  endtask

  task automatic t_held;
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b0, "R5 held");
    idle(N0 + 6, "R5 held tail");
    check("R5 back-to-back held", hi0, 3 * N0);
    check("R7 held N=1", hi1, 30);
  endtask

  task automatic t_last(input int offs, input int expHi, input string tag);
    hi0 = 0;
    tick(1'b1, 1'b0, tag);
    for (int i = 1; i <= 2 * N0 + 6; i++)
      tick((i == offs) ? 1'b1 : 1'b0, 1'b0, tag);
    check(tag, hi0, expHi);
  endtask

  task automatic t_reset_mid;
    tick(1'b1, 1'b0, "R1 mid");
    idle(5, "R1 mid");
    tick(1'b0, 1'b1, "R1 mid reset");
    check("R1 output low after reset", int'(out0), 0);
    hi0 = 0;
    idle(N0 + 2, "R1 mid after");
    check("R1 pulse cut by reset", hi0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_narrow();
    t_held();
    t_last(N0, 2 * N0, "R6 trigger on last cycle");
    t_last(N0 - 1, N0, "R6 trigger one before last");
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule